// File: doc/BRIEF.md
# Front-Panel Display and Keyscan Interface

This block is a bus slave that owns a multiplexed LED front panel and its key matrix. A bus master performs write accesses to hold annunciator segment data, digit segment data and a scan pattern. The scan pattern selects one digit, one annunciator position and one switch bank at a time. The master then reads an output buffer that returns the key state of the selected bank. A full panel refresh walks through the seven banks this way.

Only one register is decoded directly. The digit-segment register and the scan-select register respond only while an indirect-access flag is enabled. That flag is loaded from data bit 7 whenever the direct register or the scan-select register is written. A digit-segment write leaves the flag untouched, so bit 7 of that write is free for segment data. Every write takes effect when its strobe falls.

Every completed output-buffer read restarts a watchdog. If the master stops reading, the watchdog blanks the display. Key scanning carries on, and the next buffer read brings the display back.

Top module: `fp_panel_if`

## Requirements
- R1: After reset, ann_o and dig_o are zero, no bank or digit is selected, and indirect access is disabled.
- R2: A write with rd_i low to an address with bits 0, 1 and 6 all high loads data bits 6..0 into the annunciator register (ann_o) and loads data bit 7 into the indirect flag. A 1 in the flag means disabled and a 0 means enabled.
- R3: While indirect access is disabled, writes to the digit-segment register and the scan-select register leave every output unchanged.
- R4: While indirect access is enabled, a write to an address with bits 1 and 5 high loads all 8 data bits into dig_o and does not change the indirect flag.
- R5: While indirect access is enabled, a write to an address with bits 0 and 5 high stores data bits 6..0 as the scan pattern and loads data bit 7 into the flag. The lowest-numbered 0 among bits 6..0 picks bank k, and bit k of bank_sel_o and digit_sel_o goes high. An all-ones pattern selects nothing and disables indirect access.
- R6: A write uses the address and data present in the last clock cycle before strobe_i falls. The register changes at the clock edge where the fall is seen, and never while the strobe stays high.
- R7: If an address matches more than one register, the direct register wins, then the digit-segment register, then the scan-select register. Only one register is written.
- R8: While strobe_i and rd_i are high and address bits 2 and 6 are high, data_oe_o is high. In that case data_o carries sw_i as sampled at the previous clock edge, or 8'hFF when no bank is selected. At all other times data_oe_o is low.
- R9: If WDOG_CYCLES clock edges pass without a completed output-buffer read, ann_o, dig_o and digit_sel_o are forced to zero and bank_sel_o is left as it was. The next completed read ends the blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Bus access strobe, active high |
| rd_i | input | 1 | 1 = read access, 0 = write access |
| addr_i | input | 7 | Address lines |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data (output buffer) |
| data_oe_o | output | 1 | Read data drive enable; bus floats when low |
| sw_i | input | 8 | Key state of the currently selected switch bank, active low |
| ann_o | output | 7 | Annunciator segment drive |
| dig_o | output | 8 | Digit segment drive |
| digit_sel_o | output | 7 | One-hot digit/annunciator position enable |
| bank_sel_o | output | 7 | One-hot switch bank enable |

## Verification
The hardest state to reach from the ports is watchdog expiry combined with a live scan selection. Reaching it needs a direct write that enables indirect access, then a scan-select write, then a long stretch with no buffer reads. The bench runs with a shortened timeout and stops issuing reads once it has set up a bank. It then confirms that the display goes blank while the bank selection stays, and that the next read restores the display. The decode overlap cases use addresses that match two registers at once, applied under both states of the indirect flag.

// File: rtl/fp_pkg.sv
package fp_pkg;
  localparam int ADDR_W   = 7;
  localparam int DATA_W   = 8;
  localparam int NB       = DATA_W - 1;   // banks / annunciator bits
  localparam int FLAG_BIT = DATA_W - 1;

  localparam logic [ADDR_W-1:0] DIRECT_MASK = 7'b100_0011;
  localparam logic [ADDR_W-1:0] SEG_MASK    = 7'b010_0010;
  localparam logic [ADDR_W-1:0] SCAN_MASK   = 7'b010_0001;
  localparam logic [ADDR_W-1:0] OBUF_MASK   = 7'b100_0100;

  typedef struct packed {
    logic              direct;
    logic              seg;
    logic              scan;
    logic              kick;
    logic [DATA_W-1:0] data;
  } wr_cmd_t;

  function automatic logic addr_hit(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] m);
    return (a & m) == m;
  endfunction
endpackage

// File: rtl/fp_bus_decode.sv
module fp_bus_decode
  import fp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output wr_cmd_t           cmd_o
);
  logic              strobe_q;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              access_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      rd_q     <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      strobe_q <= strobe_i;
      if (strobe_i) begin
        rd_q   <= rd_i;
        addr_q <= addr_i;
        data_q <= data_i;
      end
    end
  end

  assign access_end = strobe_q & ~strobe_i;

  // priority: direct > segment > scan
  always_comb begin
    cmd_o      = '0;
    cmd_o.data = data_q;
    if (access_end) begin
      if (rd_q) begin
        cmd_o.kick = addr_hit(addr_q, OBUF_MASK);
      end else if (addr_hit(addr_q, DIRECT_MASK)) begin
        cmd_o.direct = 1'b1;
      end else if (addr_hit(addr_q, SEG_MASK)) begin
        cmd_o.seg = 1'b1;
      end else if (addr_hit(addr_q, SCAN_MASK)) begin
        cmd_o.scan = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fp_regs.sv
module fp_regs
  import fp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_cmd_t           cmd_i,
  output logic [NB-1:0]     ann_o,
  output logic [DATA_W-1:0] dig_o,
  output logic [NB-1:0]     scan_o,
  output logic              ind_dis_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ann_o     <= '0;
      dig_o     <= '0;
      scan_o    <= '1;
      ind_dis_o <= 1'b1;
    end else begin
      if (cmd_i.direct) begin
        ann_o     <= cmd_i.data[NB-1:0];
        ind_dis_o <= cmd_i.data[FLAG_BIT];
      end
      // segment write never touches the flag
      if (cmd_i.seg && !ind_dis_o) begin
        dig_o <= cmd_i.data;
      end
      if (cmd_i.scan && !ind_dis_o) begin
        scan_o    <= cmd_i.data[NB-1:0];
        ind_dis_o <= cmd_i.data[FLAG_BIT];
      end
    end
  end
endmodule

// File: rtl/fp_bank_sel.sv
module fp_bank_sel #(
  parameter int NUM = 7
) (
  input  logic [NUM-1:0] scan_i,
  output logic [NUM-1:0] onehot_o,
  output logic           valid_o
);
  logic [NUM:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NUM; i++) begin : g_pri
    assign onehot_o[i] = ~scan_i[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | ~scan_i[i];
  end

  assign valid_o = seen[NUM];
endmodule

// File: rtl/fp_watchdog.sv
module fp_watchdog #(
  parameter int CYCLES = 65536
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic expired_o
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      expired_o <= 1'b0;
    end else if (kick_i) begin
      cnt_q     <= '0;
      expired_o <= 1'b0;
    end else if (!expired_o) begin
      if (cnt_q == LAST) expired_o <= 1'b1;
      else               cnt_q     <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fp_panel_if.sv
module fp_panel_if
  import fp_pkg::*;
#(
  parameter int WDOG_CYCLES = 65536
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic [DATA_W-1:0] sw_i,
  output logic [NB-1:0]     ann_o,
  output logic [DATA_W-1:0] dig_o,
  output logic [NB-1:0]     digit_sel_o,
  output logic [NB-1:0]     bank_sel_o
);
  wr_cmd_t           cmd;
  logic [NB-1:0]     ann_q;
  logic [DATA_W-1:0] dig_q;
  logic [NB-1:0]     scan_q;
  logic              ind_dis;
  logic [NB-1:0]     bank_oh;
  logic              bank_valid;
  logic              wd_expired;
  logic [DATA_W-1:0] sw_q;

  fp_bus_decode u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobe_i),
    .rd_i    (rd_i),
    .addr_i  (addr_i),
    .data_i  (data_i),
    .cmd_o   (cmd)
  );

  fp_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_i    (cmd),
    .ann_o    (ann_q),
    .dig_o    (dig_q),
    .scan_o   (scan_q),
    .ind_dis_o(ind_dis)
  );

  fp_bank_sel #(.NUM(NB)) u_bank (
    .scan_i  (scan_q),
    .onehot_o(bank_oh),
    .valid_o (bank_valid)
  );

  fp_watchdog #(.CYCLES(WDOG_CYCLES)) u_wdog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kick_i   (cmd.kick),
    .expired_o(wd_expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sw_q <= '1;
    else         sw_q <= sw_i;
  end

  assign data_oe_o   = strobe_i & rd_i & addr_hit(addr_i, OBUF_MASK);
  assign data_o      = bank_valid ? sw_q : '1;
  assign bank_sel_o  = bank_oh;
  assign digit_sel_o = wd_expired ? '0 : bank_oh;
  assign ann_o       = wd_expired ? '0 : ann_q;
  assign dig_o       = wd_expired ? '0 : dig_q;
endmodule

// File: rtl/fp_panel_if_checker.sv
module fp_panel_if_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       strobe_i,
  input logic       rd_i,
  input logic       data_oe_o,
  input logic [6:0] ann_o,
  input logic [7:0] dig_o,
  input logic [6:0] digit_sel_o,
  input logic [6:0] bank_sel_o,
  input logic [6:0] ann_q,
  input logic [7:0] dig_q,
  input logic       ind_dis,
  input logic       wd_expired
);
  a_r5_bank_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_sel_o));

  a_r5_digit_follows_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wd_expired |-> (digit_sel_o == bank_sel_o));

  a_r9_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_expired |-> (ann_o == '0 && dig_o == '0 && digit_sel_o == '0));

  a_r3_seg_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ind_dis |=> $stable(dig_q));

  a_r8_bus_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(strobe_i && rd_i) |-> !data_oe_o);

  a_r6_hold_in_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && $past(strobe_i)) |-> ($stable(ann_q) && $stable(dig_q)));
endmodule

bind fp_panel_if fp_panel_if_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .strobe_i   (strobe_i),
  .rd_i       (rd_i),
  .data_oe_o  (data_oe_o),
  .ann_o      (ann_o),
  .dig_o      (dig_o),
  .digit_sel_o(digit_sel_o),
  .bank_sel_o (bank_sel_o),
  .ann_q      (ann_q),
  .dig_q      (dig_q),
  .ind_dis    (ind_dis),
  .wd_expired (wd_expired)
);

// File: tb/fp_panel_if_test.sv
module fp_panel_if_test;
  localparam int WD = 400;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b0;
  logic       rd_s = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] data = '0;
  logic [7:0] sw = 8'hFF;
  logic [7:0] data_o;
  logic       data_oe;
  logic [6:0] ann_o, digit_sel_o, bank_sel_o;
  logic [7:0] dig_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  fp_panel_if #(.WDOG_CYCLES(WD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .rd_i(rd_s),
    .addr_i(addr), .data_i(data), .data_o(data_o), .data_oe_o(data_oe),
    .sw_i(sw), .ann_o(ann_o), .dig_o(dig_o),
    .digit_sel_o(digit_sel_o), .bank_sel_o(bank_sel_o)
  );

  // ---------------- behavioural reference ----------------
  bit       p_strobe, p_rd;
  bit [6:0] p_addr;
  bit [7:0] p_data;
  bit [6:0] m_ann;
  bit [7:0] m_dig;
  bit [6:0] m_scan;
  bit       m_locked;
  int       m_idle;
  bit [7:0] m_sw;

  function automatic bit hits(bit [6:0] a, int b0, int b1);
    return a[b0] && a[b1];
  endfunction

  function automatic int pick_bank(bit [6:0] s);
    for (int i = 0; i < 7; i++) if (!s[i]) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_strobe = 0; p_rd = 0; p_addr = 0; p_data = 0;
      m_ann = 0; m_dig = 0; m_scan = 7'h7F; m_locked = 1; m_idle = 0; m_sw = 8'hFF;
    end else begin
      bit kicked;
      kicked = 0;
      if (p_strobe && !strobe) begin
        if (p_rd) kicked = hits(p_addr, 2, 6);
        else if (p_addr[0] && p_addr[1] && p_addr[6]) begin
          m_ann = p_data[6:0]; m_locked = p_data[7];
        end else if (hits(p_addr, 1, 5)) begin
          if (!m_locked) m_dig = p_data;
        end else if (hits(p_addr, 0, 5)) begin
          if (!m_locked) begin m_scan = p_data[6:0]; m_locked = p_data[7]; end
        end
      end
      if (kicked) m_idle = 0;
      else if (m_idle < WD) m_idle++;
      m_sw = sw;
      p_strobe = strobe;
      if (strobe) begin p_rd = rd_s; p_addr = addr; p_data = data; end
    end
  end

  task automatic report(input bit ok, input string tag, input logic [7:0] act,
                        input logic [7:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      int  k;
      bit  blank;
      bit [6:0] oh;
      k = pick_bank(m_scan);
      blank = (m_idle >= WD);
      oh = (k < 0) ? 7'h00 : 7'(1 << k);
      report(ann_o == (blank ? 7'h0 : m_ann), "R2/R9 ann_o", {1'b0, ann_o}, {1'b0, blank ? 7'h0 : m_ann});
      report(dig_o == (blank ? 8'h0 : m_dig), "R4/R9 dig_o", dig_o, blank ? 8'h0 : m_dig);
      report(bank_sel_o == oh, "R5 bank_sel_o", {1'b0, bank_sel_o}, {1'b0, oh});
      report(digit_sel_o == (blank ? 7'h0 : oh), "R5/R9 digit_sel_o", {1'b0, digit_sel_o}, {1'b0, blank ? 7'h0 : oh});
      report(data_oe == (strobe && rd_s && addr[2] && addr[6]), "R8 data_oe_o", {7'b0, data_oe}, {7'b0, strobe && rd_s && addr[2] && addr[6]});
      if (data_oe) report(data_o == ((k < 0) ? 8'hFF : m_sw), "R8 data_o", data_o, (k < 0) ? 8'hFF : m_sw);
    end
  end

  // ---------------- stimulus ----------------
  task automatic bus_cycle(input bit r, input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); strobe = 1; rd_s = r; addr = a; data = d;
    repeat (2) @(negedge clk);
    strobe = 0; rd_s = 0;
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    report(ok, tag, act, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(ann_o == 0 && dig_o == 0, "R1 display blank", dig_o, 8'h00);
    chk(bank_sel_o == 0 && digit_sel_o == 0, "R1 no bank", {1'b0, bank_sel_o}, 8'h00);
    // R1/R3 indirect disabled after reset
    bus_cycle(0, 7'h22, 8'hA5);
    chk(dig_o == 8'h00, "R3 seg write ignored", dig_o, 8'h00);
    bus_cycle(0, 7'h21, 8'h7E);
    chk(bank_sel_o == 0, "R3 scan write ignored", {1'b0, bank_sel_o}, 8'h00);
    // R2 direct write, enable indirect
    bus_cycle(0, 7'h43, 8'h15);
    chk(ann_o == 7'h15, "R2 ann load", {1'b0, ann_o}, 8'h15);
    // R6 capture at strobe end with last data
    @(negedge clk); strobe = 1; rd_s = 0; addr = 7'h43; data = 8'h2A;
    repeat (2) @(negedge clk);
    chk(ann_o == 7'h15, "R6 no change during strobe", {1'b0, ann_o}, 8'h15);
    data = 8'h33;
    @(negedge clk); strobe = 0;
    @(negedge clk);
    chk(ann_o == 7'h33, "R6 last data captured", {1'b0, ann_o}, 8'h33);
    // R4 seg write with bit7 high keeps flag
    bus_cycle(0, 7'h22, 8'hFF);
    chk(dig_o == 8'hFF, "R4 seg load", dig_o, 8'hFF);
    bus_cycle(0, 7'h21, 8'h7B);
    chk(bank_sel_o == 7'h04, "R5 bank 2", {1'b0, bank_sel_o}, 8'h04);
    bus_cycle(0, 7'h22, 8'h81);
    chk(dig_o == 8'h81, "R4 flag untouched", dig_o, 8'h81);
    // R5 several lows -> lowest
    bus_cycle(0, 7'h21, 8'h76);
    chk(bank_sel_o == 7'h01 && digit_sel_o == 7'h01, "R5 lowest bank", {1'b0, bank_sel_o}, 8'h01);
    // R8 buffer read
    sw = 8'hEF;
    @(negedge clk); strobe = 1; rd_s = 1; addr = 7'h44;
    @(negedge clk);
    chk(data_oe == 1 && data_o == 8'hEF, "R8 read bank", data_o, 8'hEF);
    strobe = 0; rd_s = 0;
    @(negedge clk);
    chk(data_oe == 0, "R8 bus floats", {7'b0, data_oe}, 8'h00);
    // R5 all ones: no bank, indirect disabled
    bus_cycle(0, 7'h21, 8'hFF);
    chk(bank_sel_o == 0, "R5 all ones no bank", {1'b0, bank_sel_o}, 8'h00);
    bus_cycle(0, 7'h22, 8'h00);
    chk(dig_o == 8'h81, "R3 locked after all ones", dig_o, 8'h81);
    @(negedge clk); strobe = 1; rd_s = 1; addr = 7'h44;
    @(negedge clk);
    chk(data_o == 8'hFF, "R8 no bank reads FF", data_o, 8'hFF);
    strobe = 0; rd_s = 0;
    // R7 overlap priority
    bus_cycle(0, 7'h63, 8'h05);
    chk(ann_o == 7'h05, "R7 direct wins", {1'b0, ann_o}, 8'h05);
    bus_cycle(0, 7'h23, 8'h7D);
    chk(dig_o == 8'h7D && bank_sel_o == 0, "R7 seg over scan", dig_o, 8'h7D);
    // R9 watchdog
    bus_cycle(0, 7'h21, 8'h7D);
    bus_cycle(1, 7'h44, 8'h00);
    repeat (WD + 4) @(negedge clk);
    chk(ann_o == 0 && dig_o == 0 && digit_sel_o == 0, "R9 blanked", dig_o, 8'h00);
    chk(bank_sel_o == 7'h02, "R9 bank kept", {1'b0, bank_sel_o}, 8'h02);
    bus_cycle(1, 7'h44, 8'h00);
    chk(ann_o == 7'h05 && digit_sel_o == 7'h02, "R9 restored", {1'b0, ann_o}, 8'h05);
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++; errors++;
      $display("FAIL watchdog timeout actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule